// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a bank of token flags shared by two independent ports, called side A (left) and side B (right). Software on either side claims a shared resource by writing a low level into the flag that stands for it, then reading the flag back. A read of all zeros means the token now belongs to that side. A read of all ones means the flag is free, or that the other side holds it. The side that holds a token hands it back by writing a high level.

Each flag keeps one request latch per side. A request from the side that does not hold the token is remembered. The token passes to that side the moment the owner releases it, so a waiting side never has to poll with repeated writes. Two requests for a free flag on the same clock edge are resolved by a fixed rule. Side A wins by default, and a parameter can give the tie to side B instead.

Each port has a one-bit read hold register. It captures the port's view of the addressed flag when a read begins and keeps it until the read ends. Activity on the other port therefore cannot change a value in the middle of a read. All logic runs on one clock and uses an active-low reset.

Top module: `tok_sem_bank`

## Requirements
- R1: After reset, every flag is free and both request latches of every flag are clear, so both ports read 16'hFFFF from every flag.
- R2: A port writes a flag when its select and write strobe are both 1 at a clock edge, and the address picks the flag. When a port writes data bit 0 = 0 to a free flag and the other side makes no request for that flag on the same edge, that port owns the flag. From the next cycle, the owner reads 16'h0000 and the other port reads 16'hFFFF.
- R3: A write uses only data bit 0, and bits 15..1 have no effect. Only the addressed flag changes; the other seven flags keep their state.
- R4: At most one side owns a flag at any time. If both sides request a free flag on the same edge, side A (the default tie rule) owns it, and side B's request stays pending.
- R5: A 0 written by the side that does not own the flag is kept as a pending request. When the owner writes 1, ownership passes to the waiting side on that same edge, so the new owner reads 16'h0000 on the next read.
- R6: An owner that writes 1 while no request is pending frees the flag, and both ports then read 16'hFFFF.
- R7: These writes leave ownership unchanged: a 0 written by the owner; a 1 written by a side that neither owns the flag nor is waiting for it. A 1 written by a waiting side cancels its request and does not give it the token.
- R8: A read shows the flag on all 16 data bits, so the read data is either 16'h0000 or 16'hFFFF.
- R9: A port captures its read value at the first clock edge where its select and output enable are both 1. The value stays frozen while both stay 1, even if the flag changes in the meantime. A new capture needs one edge where the two are not both 1.
- R10: A write strobe without the port's select has no effect. A write made at one edge can be read back by a read whose capture edge is the next edge or a later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel | input | 1 | Side A semaphore select, active high |
| a_oe | input | 1 | Side A output enable, active high |
| a_we | input | 1 | Side A write strobe, active high |
| a_addr | input | 3 | Side A flag address |
| a_wdata | input | 16 | Side A write data; only bit 0 is used |
| a_rdata | output | 16 | Side A read data (held flag value on all bits) |
| b_sel | input | 1 | Side B semaphore select, active high |
| b_oe | input | 1 | Side B output enable, active high |
| b_we | input | 1 | Side B write strobe, active high |
| b_addr | input | 3 | Side B flag address |
| b_wdata | input | 16 | Side B write data; only bit 0 is used |
| b_rdata | output | 16 | Side B read data (held flag value on all bits) |

## Verification
The properties assume that each port's controls are known and stable around every clock edge. They also assume that a read which begins on an edge does not write on that same edge. The bench drives inputs only on falling edges and opens each read on its own, without a write on the opening edge. The one place where a write lands inside a held read is the freeze test, and that write comes after the capture edge. Same-edge requests from both sides are driven on purpose, so the tie rule and the pending request it leaves behind are both exercised.

// File: rtl/tok_sem_pkg.sv
package tok_sem_pkg;

   // Which side wins a same-edge request for a free flag
   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   localparam int unsigned DEF_FLAGS  = 8;
   localparam int unsigned DEF_ADDR_W = 3;
   localparam int unsigned DEF_DATA_W = 16;

endpackage

// File: rtl/tok_sem_decode.sv
// Turns one port's strobe, address and data bit 0 into per-flag
// request and release pulses.
module tok_sem_decode #(
   parameter int unsigned NUM_FLAGS = 8,
   parameter int unsigned ADDR_W    = 3
) (
   input  logic                 sel,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wbit,
   output logic [NUM_FLAGS-1:0] req,
   output logic [NUM_FLAGS-1:0] rel
);

   logic [NUM_FLAGS-1:0] hit;

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hit
      assign hit[i] = sel && we && (addr == ADDR_W'(i));
      assign req[i] = hit[i] && !wbit;
      assign rel[i] = hit[i] &&  wbit;
   end

endmodule

// File: rtl/tok_sem_cell.sv
// One token flag: a request latch per side plus ownership state.
module tok_sem_cell #(
   parameter tok_sem_pkg::side_e TIE_WINNER = tok_sem_pkg::SIDE_A
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_a,
   input  logic rel_a,
   input  logic req_b,
   input  logic rel_b,
   output logic own_a,
   output logic own_b,
   output logic want_a,
   output logic want_b
);

   logic want_a_q, want_b_q, own_a_q, own_b_q;
   logic want_a_d, want_b_d, own_a_d, own_b_d;
   logic tie_to_a;

   if (TIE_WINNER == tok_sem_pkg::SIDE_A) begin : g_tie_a
      assign tie_to_a = 1'b1;
   end else begin : g_tie_b
      assign tie_to_a = 1'b0;
   end

   always_comb begin
      want_a_d = req_a ? 1'b1 : (rel_a ? 1'b0 : want_a_q);
      want_b_d = req_b ? 1'b1 : (rel_b ? 1'b0 : want_b_q);
      own_a_d  = own_a_q;
      own_b_d  = own_b_q;
      if (own_a_q) begin
         if (!want_a_d) begin
            own_a_d = 1'b0;
            own_b_d = want_b_d;
         end
      end else if (own_b_q) begin
         if (!want_b_d) begin
            own_b_d = 1'b0;
            own_a_d = want_a_d;
         end
      end else if (want_a_d && want_b_d) begin
         own_a_d = tie_to_a;
         own_b_d = !tie_to_a;
      end else begin
         own_a_d = want_a_d;
         own_b_d = want_b_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         want_a_q <= 1'b0;
         want_b_q <= 1'b0;
         own_a_q  <= 1'b0;
         own_b_q  <= 1'b0;
      end else begin
         want_a_q <= want_a_d;
         want_b_q <= want_b_d;
         own_a_q  <= own_a_d;
         own_b_q  <= own_b_d;
      end
   end

   assign own_a  = own_a_q;
   assign own_b  = own_b_q;
   assign want_a = want_a_q;
   assign want_b = want_b_q;

endmodule

// File: rtl/tok_sem_hold.sv
// Per-port read hold: captures the addressed flag view when a read
// opens and keeps it while select and output enable stay active.
module tok_sem_hold #(
   parameter int unsigned NUM_FLAGS = 8,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DATA_W    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 oe,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_FLAGS-1:0] view_one,
   output logic [DATA_W-1:0]    rdata
);

   logic rd_now, act_q, bit_q, pick;

   assign rd_now = sel && oe;
   assign pick   = (int'(addr) < NUM_FLAGS) ? view_one[addr] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         bit_q <= 1'b1;
      end else begin
         act_q <= rd_now;
         if (rd_now && !act_q) begin
            bit_q <= pick;
         end
      end
   end

   assign rdata = {DATA_W{bit_q}};

endmodule

// File: rtl/tok_sem_bank.sv
module tok_sem_bank #(
   parameter int unsigned        NUM_FLAGS  = tok_sem_pkg::DEF_FLAGS,
   parameter int unsigned        ADDR_W     = tok_sem_pkg::DEF_ADDR_W,
   parameter int unsigned        DATA_W     = tok_sem_pkg::DEF_DATA_W,
   parameter tok_sem_pkg::side_e TIE_WINNER = tok_sem_pkg::SIDE_A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_sel,
   input  logic              a_oe,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_sel,
   input  logic              b_oe,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (NUM_FLAGS < 2 || NUM_FLAGS > ADDR_SPAN) begin : g_bad_flags
      $error("tok_sem_bank: NUM_FLAGS must lie in 2..2**ADDR_W");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("tok_sem_bank: DATA_W must be at least 1");
   end

   logic [NUM_FLAGS-1:0] req_a, rel_a, req_b, rel_b;
   logic [NUM_FLAGS-1:0] own_a, own_b, want_a, want_b;

   tok_sem_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_a (
      .sel(a_sel), .we(a_we), .addr(a_addr), .wbit(a_wdata[0]),
      .req(req_a), .rel(rel_a)
   );

   tok_sem_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_b (
      .sel(b_sel), .we(b_we), .addr(b_addr), .wbit(b_wdata[0]),
      .req(req_b), .rel(rel_b)
   );

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      tok_sem_cell #(.TIE_WINNER(TIE_WINNER)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .req_a(req_a[i]), .rel_a(rel_a[i]),
         .req_b(req_b[i]), .rel_b(rel_b[i]),
         .own_a(own_a[i]), .own_b(own_b[i]),
         .want_a(want_a[i]), .want_b(want_b[i])
      );
   end

   tok_sem_hold #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold_a (
      .clk(clk), .rst_n(rst_n), .sel(a_sel), .oe(a_oe), .addr(a_addr),
      .view_one(~own_a), .rdata(a_rdata)
   );

   tok_sem_hold #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold_b (
      .clk(clk), .rst_n(rst_n), .sel(b_sel), .oe(b_oe), .addr(b_addr),
      .view_one(~own_b), .rdata(b_rdata)
   );

endmodule

// File: rtl/tok_sem_bank_chk.sv
module tok_sem_bank_chk #(
   parameter int unsigned        NUM_FLAGS  = 8,
   parameter int unsigned        ADDR_W     = 3,
   parameter int unsigned        DATA_W     = 16,
   parameter tok_sem_pkg::side_e TIE_WINNER = tok_sem_pkg::SIDE_A
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 a_sel,
   input logic                 a_oe,
   input logic                 a_we,
   input logic [ADDR_W-1:0]    a_addr,
   input logic [DATA_W-1:0]    a_wdata,
   input logic [DATA_W-1:0]    a_rdata,
   input logic                 b_sel,
   input logic                 b_oe,
   input logic                 b_we,
   input logic [ADDR_W-1:0]    b_addr,
   input logic [DATA_W-1:0]    b_wdata,
   input logic [DATA_W-1:0]    b_rdata,
   input logic [NUM_FLAGS-1:0] own_a,
   input logic [NUM_FLAGS-1:0] own_b,
   input logic [NUM_FLAGS-1:0] want_a,
   input logic [NUM_FLAGS-1:0] want_b
);

   logic a_rd, b_rd;
   assign a_rd = a_sel && a_oe;
   assign b_rd = b_sel && b_oe;

   // R4: never two owners
   a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (own_a & own_b) == '0);

   // R8: read data is all ones or all zeros
   a_r8_spread_a: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rdata == '0) || (a_rdata == '1));
   a_r8_spread_b: assert property (@(posedge clk) disable iff (!rst_n)
      (b_rdata == '0) || (b_rdata == '1));

   // R9: held read value does not move while the read stays open
   a_r9_freeze_a: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && $past(a_rd)) |=> (!a_rd || $stable(a_rdata)));
   a_r9_freeze_b: assert property (@(posedge clk) disable iff (!rst_n)
      (b_rd && $past(b_rd)) |=> (!b_rd || $stable(b_rdata)));

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_prop
      logic ar, al, br, bl;
      assign ar = a_sel && a_we && (a_addr == ADDR_W'(i)) && !a_wdata[0];
      assign al = a_sel && a_we && (a_addr == ADDR_W'(i)) &&  a_wdata[0];
      assign br = b_sel && b_we && (b_addr == ADDR_W'(i)) && !b_wdata[0];
      assign bl = b_sel && b_we && (b_addr == ADDR_W'(i)) &&  b_wdata[0];

      // R2: uncontested request on a free flag wins it
      a_r2_grant_a: assert property (@(posedge clk) disable iff (!rst_n)
         (!own_a[i] && !own_b[i] && ar && !br) |=> own_a[i]);
      a_r2_grant_b: assert property (@(posedge clk) disable iff (!rst_n)
         (!own_a[i] && !own_b[i] && br && !ar) |=> own_b[i]);

      // R7: owner keeps the token until it releases
      a_r7_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
         (own_a[i] && !al) |=> own_a[i]);
      a_r7_keep_b: assert property (@(posedge clk) disable iff (!rst_n)
         (own_b[i] && !bl) |=> own_b[i]);

      // R5: release hands over to a waiting side
      a_r5_handover_ab: assert property (@(posedge clk) disable iff (!rst_n)
         (own_a[i] && al && want_b[i] && !bl) |=> own_b[i]);
      a_r5_handover_ba: assert property (@(posedge clk) disable iff (!rst_n)
         (own_b[i] && bl && want_a[i] && !al) |=> own_a[i]);

      // R6: release with nobody waiting frees the flag
      a_r6_free: assert property (@(posedge clk) disable iff (!rst_n)
         (own_a[i] && al && !want_b[i] && !br) |=> (!own_a[i] && !own_b[i]));

      // R4: tie on a free flag goes to the configured side, loser waits
      if (TIE_WINNER == tok_sem_pkg::SIDE_A) begin : g_tie_a
         a_r4_tie: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_a[i] && !own_b[i] && ar && br) |=> (own_a[i] && want_b[i]));
      end else begin : g_tie_b
         a_r4_tie: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_a[i] && !own_b[i] && ar && br) |=> (own_b[i] && want_a[i]));
      end
   end

endmodule

bind tok_sem_bank tok_sem_bank_chk #(
   .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIE_WINNER(TIE_WINNER)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .a_sel(a_sel), .a_oe(a_oe), .a_we(a_we), .a_addr(a_addr),
   .a_wdata(a_wdata), .a_rdata(a_rdata),
   .b_sel(b_sel), .b_oe(b_oe), .b_we(b_we), .b_addr(b_addr),
   .b_wdata(b_wdata), .b_rdata(b_rdata),
   .own_a(own_a), .own_b(own_b), .want_a(want_a), .want_b(want_b)
);

// File: tb/tok_sem_bank_test.sv
`timescale 1ns/1ps
module tok_sem_bank_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_sel = 0, a_oe = 0, a_we = 0;
   logic b_sel = 0, b_oe = 0, b_we = 0;
   logic [2:0]  a_addr = '0, b_addr = '0;
   logic [15:0] a_wdata = '0, b_wdata = '0;
   logic [15:0] a_rdata, b_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tok_sem_bank uut (
      .clk(clk), .rst_n(rst_n),
      .a_sel(a_sel), .a_oe(a_oe), .a_we(a_we), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_sel(b_sel), .b_oe(b_oe), .b_we(b_we), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_rdata(b_rdata)
   );

   // ---------------- behavioural reference ----------------
   int m_own [8];      // 0 free, 1 side A, 2 side B
   bit m_wa [8];
   bit m_wb [8];
   bit m_hold_a = 1, m_hold_b = 1, m_act_a = 0, m_act_b = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int f = 0; f < 8; f++) begin
            m_own[f] = 0; m_wa[f] = 0; m_wb[f] = 0;
         end
         m_hold_a = 1; m_hold_b = 1; m_act_a = 0; m_act_b = 0;
      end else begin
         if (a_sel && a_oe && !m_act_a) m_hold_a = (m_own[a_addr] != 1);
         if (b_sel && b_oe && !m_act_b) m_hold_b = (m_own[b_addr] != 2);
         m_act_a = a_sel && a_oe;
         m_act_b = b_sel && b_oe;
         if (a_sel && a_we) m_wa[a_addr] = !a_wdata[0];
         if (b_sel && b_we) m_wb[b_addr] = !b_wdata[0];
         for (int f = 0; f < 8; f++) begin
            if (m_own[f] == 1) begin
               if (!m_wa[f]) m_own[f] = m_wb[f] ? 2 : 0;
            end else if (m_own[f] == 2) begin
               if (!m_wb[f]) m_own[f] = m_wa[f] ? 1 : 0;
            end else if (m_wa[f]) m_own[f] = 1;
            else if (m_wb[f]) m_own[f] = 2;
         end
      end
   end

   // per-clock comparison of both read buses (R8, R9)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (a_rdata !== {16{m_hold_a}} || b_rdata !== {16{m_hold_b}}) begin
            failures++;
            $display("FAIL R9 per-clock model: a=%h/%h b=%h/%h", a_rdata,
                     {16{m_hold_a}}, b_rdata, {16{m_hold_b}});
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic expect16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit side_b, input int f, input logic [15:0] d);
      @(negedge clk);
      if (!side_b) begin a_sel = 1; a_we = 1; a_addr = 3'(f); a_wdata = d; end
      else         begin b_sel = 1; b_we = 1; b_addr = 3'(f); b_wdata = d; end
      @(negedge clk);
      a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
   endtask

   task automatic wr_both(input int f, input logic [15:0] da, input logic [15:0] db);
      @(negedge clk);
      a_sel = 1; a_we = 1; a_addr = 3'(f); a_wdata = da;
      b_sel = 1; b_we = 1; b_addr = 3'(f); b_wdata = db;
      @(negedge clk);
      a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
   endtask

   task automatic rd(input bit side_b, input int f, output logic [15:0] v);
      @(negedge clk);
      if (!side_b) begin a_sel = 1; a_oe = 1; a_addr = 3'(f); end
      else         begin b_sel = 1; b_oe = 1; b_addr = 3'(f); end
      @(negedge clk);
      v = side_b ? b_rdata : a_rdata;
      a_sel = 0; a_oe = 0; b_sel = 0; b_oe = 0;
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      for (int f = 0; f < 8; f++) begin
         rd(0, f, v); expect16("R1 side A after reset", v, 16'hFFFF);
         rd(1, f, v); expect16("R1 side B after reset", v, 16'hFFFF);
      end

      // R2, R3, R8, R10: request with upper data bits set
      wr(0, 3, 16'hFFFE);
      rd(0, 3, v); expect16("R2 R8 R10 owner A reads zeros", v, 16'h0000);
      rd(1, 3, v); expect16("R2 other side B reads ones", v, 16'hFFFF);
      rd(0, 2, v); expect16("R3 neighbour flag untouched", v, 16'hFFFF);
      rd(0, 4, v); expect16("R3 neighbour flag untouched", v, 16'hFFFF);

      // R7: stray release from B (no ownership, nothing pending)
      wr(1, 3, 16'h0001);
      rd(0, 3, v); expect16("R7 stray release ignored", v, 16'h0000);

      // R5: B waits; R7: A re-requests; then A releases -> handover
      wr(1, 3, 16'h0000);
      rd(1, 3, v); expect16("R5 waiting side B still reads ones", v, 16'hFFFF);
      wr(0, 3, 16'h0000);
      rd(0, 3, v); expect16("R7 owner re-request no change", v, 16'h0000);
      wr(0, 3, 16'h0001);
      rd(1, 3, v); expect16("R5 handover to B", v, 16'h0000);
      rd(0, 3, v); expect16("R5 A lost token", v, 16'hFFFF);

      // R6: release with nobody waiting
      wr(1, 3, 16'h0001);
      rd(0, 3, v); expect16("R6 free on A", v, 16'hFFFF);
      rd(1, 3, v); expect16("R6 free on B", v, 16'hFFFF);

      // R4: same-edge requests, A wins, B stays pending
      wr_both(6, 16'h0000, 16'h8000);
      rd(0, 6, v); expect16("R4 tie won by A", v, 16'h0000);
      rd(1, 6, v); expect16("R4 tie loser B reads ones", v, 16'hFFFF);
      wr(0, 6, 16'h0001);
      rd(1, 6, v); expect16("R4 B request stayed pending", v, 16'h0000);
      wr(1, 6, 16'h0001);
      rd(1, 6, v); expect16("R6 flag 6 free again", v, 16'hFFFF);

      // R7: waiting side withdraws, no token afterwards
      wr(0, 1, 16'h0000);
      wr(1, 1, 16'h0000);
      wr(1, 1, 16'h0001);
      wr(0, 1, 16'h0001);
      rd(1, 1, v); expect16("R7 withdrawn request gets no token", v, 16'hFFFF);
      rd(0, 1, v); expect16("R7 flag 1 free", v, 16'hFFFF);

      // R10: write strobe without select has no effect
      @(negedge clk);
      a_we = 1; a_addr = 3'd5; a_wdata = 16'h0000;
      @(negedge clk);
      a_we = 0;
      rd(0, 5, v); expect16("R10 unselected write ignored", v, 16'hFFFF);
      rd(1, 5, v); expect16("R10 unselected write ignored B", v, 16'hFFFF);

      // R9: A holds a read while its token passes to B
      wr(0, 2, 16'h0000);
      wr(1, 2, 16'h0000);
      @(negedge clk);
      a_sel = 1; a_oe = 1; a_addr = 3'd2;
      @(negedge clk);
      expect16("R9 captured value", a_rdata, 16'h0000);
      a_we = 1; a_wdata = 16'h0001;
      @(negedge clk);
      a_we = 0;
      @(negedge clk);
      expect16("R9 frozen after handover", a_rdata, 16'h0000);
      a_sel = 0; a_oe = 0;
      rd(0, 2, v); expect16("R9 fresh read after reopen", v, 16'hFFFF);
      rd(1, 2, v); expect16("R5 B owns flag 2", v, 16'h0000);

      // R8: spread check on both buses
      expect16("R8 side B bus level", (b_rdata == 16'h0000 || b_rdata == 16'hFFFF) ? 16'h1 : 16'h0, 16'h1);

      repeat (2) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule